// File: doc/BRIEF.md
# Multiprocessor Interrupt Distributor

This block gathers interrupt requests from a mix of sources and hands each one to one of four CPUs. The sources are external request lines, a bank of down-counting timers, message mailboxes and CPU-to-CPU doorbells. External requests arrive in one of two forms. In parallel form there are eight plain level lines. In serial form, sixteen levels are shifted in on a single data wire after a sync strobe.

Each source carries its own settings: a priority, a mask, a target CPU and a delivery class. A source in the standard class competes against the target CPU's task priority and against the interrupt that CPU is already servicing. A source in the critical class skips those comparisons and drives a separate output for that CPU.

Software reads an acknowledge register for a CPU to learn which source won. That read also retires edge-type events. Software then writes the same address to signal end of interrupt. The block carries no data streams. Its register port is a plain single-cycle strobe interface with no back-pressure: a write takes effect at the clock edge where `wr_en` is high, and read data appears one cycle after `rd_en`.

Top module: `mp_irq_ctrl`

## Requirements
- R1: After reset every source is masked (config byte 0x10), `irq_out` and `crit_out` are low, and an acknowledge read with nothing eligible returns 0xFF.
- R2: The source config byte at word address s (s = 0..27) reads back as written, with these fields: bit 7 critical, bits 6:5 target CPU, bit 4 mask, bits 3:0 priority. A masked source is never delivered.
- R3: `irq_out[c]` rises one cycle after state changes when some unmasked, pending, standard-class source with a nonzero priority targets CPU c, and its priority is greater than the task priority of c (address 32+c) and greater than the priority in service on c.
- R4: An acknowledge read at address 36+c returns the source number. Critical candidates win over standard ones. Among the candidates, the highest priority wins, and on equal priority the lowest source number wins. A standard winner becomes the one in-service level of c. An edge source is cleared by its acknowledge. With no candidate the read returns 0xFF.
- R5: A write to address 36+c clears the in-service level of CPU c.
- R6: `crit_out[c]` is high while an unmasked, pending, critical-class source targets c, whatever the task priority.
- R7: In parallel mode (address 53, bit 0 clear), `irq_in[i]` is the level of source i for i = 0..7, and sources 8..15 stay idle.
- R8: In serial mode, a high `ser_sync` starts a frame. The next 16 cycles of `ser_data` are taken first bit to source 15, last bit to source 0. The frame becomes the level of sources 0..15 when its last bit arrives, and `irq_in` is then ignored.
- R9: A write to mailbox address 40+m stores 32 bits that read back unchanged and raises edge source 20+m.
- R10: A write to address 44 raises doorbell source 24+k for every set bit k of the data. Doorbell k always targets CPU k, whatever its target field says.
- R11: Timer t has its reload at address 48+t, its enables in bits 3:0 of address 52 and its chain bits in bits 7:4 of address 52. An enabled timer counts down once per cycle. On a step taken at zero it reloads and raises edge source 16+t, so the period is reload+1 steps.
- R12: A timer with its chain bit set (t > 0) steps only on cycles when timer t-1 wraps.
- R13: `rd_data` changes only on the cycle after a read strobe and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Parallel external request levels |
| ser_sync | input | 1 | Serial frame start strobe |
| ser_data | input | 1 | Serial request data, first bit is source 15 |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 6 | Register word address |
| wdata | input | 32 | Register write data |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en` |
| irq_out | output | 4 | Standard interrupt per CPU |
| crit_out | output | 4 | Critical interrupt per CPU |

## Verification
Directed patterns isolate one rule each:
- Two sources of equal priority show that ties go to the lower source number.
- Raising a second, higher source while the first is in service separates in-service blocking from task-priority blocking.
- A critical source sent under a task priority of 15 shows that this class bypasses the threshold.
- A serial frame with a single set bit, sent while every parallel line is high, proves both the bit order and that the parallel lines are ignored.
- A chained timer pair is sampled before and after its expected wrap cycle to tell chained from free counting.

Seeded random priorities, masks, levels and task priorities on the parallel lines then compare every acknowledge result with a bench-side arbitration function.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NCPU     = 4;
  localparam int NEXT     = 16;
  localparam int NDISC    = 8;
  localparam int NTMR     = 4;
  localparam int NMSG     = 4;
  localparam int NSRC     = NEXT + NTMR + NMSG + NCPU;
  localparam int TMR_BASE = NEXT;
  localparam int MSG_BASE = TMR_BASE + NTMR;
  localparam int IPI_BASE = MSG_BASE + NMSG;
  localparam int SRC_W    = $clog2(NSRC);
  localparam int CPU_W    = $clog2(NCPU);
  localparam int PRI_W    = 4;

  localparam int A_TASK = 32;
  localparam int A_ACK  = 36;
  localparam int A_MSG  = 40;
  localparam int A_IPI  = 44;
  localparam int A_RLD  = 48;
  localparam int A_TCTL = 52;
  localparam int A_MODE = 53;

  localparam logic [7:0] SPURIOUS = 8'hFF;

  typedef struct packed {
    logic             crit;
    logic [CPU_W-1:0] dest;
    logic             mask;
    logic [PRI_W-1:0] prio;
  } src_cfg_t;
endpackage

// File: rtl/irq_serial_rx.sv
module irq_serial_rx #(
  parameter int NBITS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_i,
  input  logic             data_i,
  output logic [NBITS-1:0] bits_o,
  output logic             done_o
);
  localparam int CW = $clog2(NBITS + 1);

  logic [CW-1:0]    cnt;
  logic [NBITS-1:0] sh;

  // high on the cycle whose edge takes the final bit
  assign done_o = (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      sh     <= '0;
      bits_o <= '0;
    end else if (sync_i) begin
      cnt <= CW'(NBITS);
    end else if (cnt != '0) begin
      sh  <= {sh[NBITS-2:0], data_i};
      cnt <= cnt - CW'(1);
      if (done_o) bits_o <= {sh[NBITS-2:0], data_i};
    end
  end
endmodule

// File: rtl/irq_timer_bank.sv
module irq_timer_bank #(
  parameter int NT = 4,
  parameter int W  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NT-1:0] en_i,
  input  logic [NT-1:0] casc_i,
  input  logic [NT-1:0] ld_i,
  input  logic [W-1:0]  ld_val_i,
  output logic [NT-1:0] wrap_o
);
  logic [W-1:0]  cnt [NT];
  logic [W-1:0]  rld [NT];
  logic [NT-1:0] step;

  for (genvar t = 0; t < NT; t++) begin : g_tmr
    if (t == 0) begin : g_head
      assign step[t] = en_i[t];
    end else begin : g_link
      assign step[t] = en_i[t] && (casc_i[t] ? wrap_o[t-1] : 1'b1);
    end
    assign wrap_o[t] = step[t] && (cnt[t] == '0);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt[t] <= '0;
        rld[t] <= '0;
      end else if (ld_i[t]) begin
        cnt[t] <= ld_val_i;
        rld[t] <= ld_val_i;
      end else if (step[t]) begin
        cnt[t] <= (cnt[t] == '0) ? rld[t] : cnt[t] - W'(1);
      end
    end
  end
endmodule

// File: rtl/irq_cpu_sel.sv
module irq_cpu_sel #(
  parameter int NS = 28,
  parameter int PW = 4,
  parameter int IW = 5
) (
  input  logic [NS-1:0]    std_i,
  input  logic [NS-1:0]    crit_i,
  input  logic [NS*PW-1:0] pri_i,
  output logic             std_v_o,
  output logic [IW-1:0]    std_idx_o,
  output logic [PW-1:0]    std_pri_o,
  output logic             crit_v_o,
  output logic [IW-1:0]    crit_idx_o
);
  logic [PW-1:0] crit_pri;

  // scan downward with >= so that equal priorities settle on the lowest index
  always_comb begin
    std_v_o    = 1'b0;
    std_idx_o  = '0;
    std_pri_o  = '0;
    crit_v_o   = 1'b0;
    crit_idx_o = '0;
    crit_pri   = '0;
    for (int i = NS - 1; i >= 0; i--) begin
      if (std_i[i] && (!std_v_o || pri_i[i*PW +: PW] >= std_pri_o)) begin
        std_v_o   = 1'b1;
        std_idx_o = IW'(i);
        std_pri_o = pri_i[i*PW +: PW];
      end
      if (crit_i[i] && (!crit_v_o || pri_i[i*PW +: PW] >= crit_pri)) begin
        crit_v_o   = 1'b1;
        crit_idx_o = IW'(i);
        crit_pri   = pri_i[i*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/mp_irq_ctrl.sv
module mp_irq_ctrl
  import irq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TMR_W  = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NDISC-1:0]  irq_in,
  input  logic              ser_sync,
  input  logic              ser_data,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic [NCPU-1:0]   irq_out,
  output logic [NCPU-1:0]   crit_out
);
  src_cfg_t             cfg [NSRC];
  logic [PRI_W-1:0]     task_pri [NCPU];
  logic [PRI_W-1:0]     insvc_pri [NCPU];
  logic [NCPU-1:0]      insvc_v;
  logic [DATA_W-1:0]    msg_data [NMSG];
  logic [NSRC-1:NEXT]   edge_pend;
  logic                 ser_mode;
  logic [NTMR-1:0]      tmr_en, tmr_casc, tmr_ld, tmr_wrap;
  logic [NEXT-1:0]      ser_bits, ext_lvl;
  logic                 ser_done;
  logic [NSRC-1:0]      pend;
  logic [NSRC*PRI_W-1:0] pri_flat;
  logic [NSRC-1:0]      std_vec [NCPU];
  logic [NSRC-1:0]      crit_vec [NCPU];
  logic [NCPU-1:0]      best_v, crit_v, present;
  logic [SRC_W-1:0]     best_idx [NCPU];
  logic [SRC_W-1:0]     crit_idx [NCPU];
  logic [PRI_W-1:0]     best_pri [NCPU];
  logic                 ack_hit, ack_take, ack_std;
  logic [CPU_W-1:0]     ack_cpu;
  logic [SRC_W-1:0]     ack_src;
  logic [7:0]           ack_vec;
  logic [DATA_W-1:0]    rd_next;

  irq_serial_rx #(.NBITS(NEXT)) u_ser (
    .clk(clk), .rst_n(rst_n), .sync_i(ser_sync), .data_i(ser_data),
    .bits_o(ser_bits), .done_o(ser_done)
  );

  always_comb begin
    for (int t = 0; t < NTMR; t++) tmr_ld[t] = wr_en && (addr == ADDR_W'(A_RLD + t));
  end

  irq_timer_bank #(.NT(NTMR), .W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .en_i(tmr_en), .casc_i(tmr_casc),
    .ld_i(tmr_ld), .ld_val_i(wdata[TMR_W-1:0]), .wrap_o(tmr_wrap)
  );

  assign ext_lvl = ser_mode ? ser_bits : {{(NEXT-NDISC){1'b0}}, irq_in};
  assign pend    = {edge_pend, ext_lvl};

  // eligibility per CPU; doorbells are hard-wired to their own CPU
  always_comb begin
    logic [CPU_W-1:0] rt;
    logic             ok;
    for (int s = 0; s < NSRC; s++) pri_flat[s*PRI_W +: PRI_W] = cfg[s].prio;
    for (int c = 0; c < NCPU; c++) begin
      for (int s = 0; s < NSRC; s++) begin
        rt = (s >= IPI_BASE) ? CPU_W'(s - IPI_BASE) : cfg[s].dest;
        ok = pend[s] && !cfg[s].mask && (rt == CPU_W'(c));
        std_vec[c][s]  = ok && !cfg[s].crit && (cfg[s].prio != '0);
        crit_vec[c][s] = ok && cfg[s].crit;
      end
    end
  end

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    irq_cpu_sel #(.NS(NSRC), .PW(PRI_W), .IW(SRC_W)) u_sel (
      .std_i(std_vec[c]), .crit_i(crit_vec[c]), .pri_i(pri_flat),
      .std_v_o(best_v[c]), .std_idx_o(best_idx[c]), .std_pri_o(best_pri[c]),
      .crit_v_o(crit_v[c]), .crit_idx_o(crit_idx[c])
    );
    logic [PRI_W-1:0] thr;
    assign thr = (insvc_v[c] && insvc_pri[c] > task_pri[c]) ? insvc_pri[c] : task_pri[c];
    assign present[c] = best_v[c] && (best_pri[c] > thr);
  end

  always_comb begin
    ack_hit = 1'b0;
    ack_cpu = '0;
    for (int c = 0; c < NCPU; c++) begin
      if (addr == ADDR_W'(A_ACK + c)) begin
        ack_hit = rd_en;
        ack_cpu = CPU_W'(c);
      end
    end
    ack_take = crit_v[ack_cpu] || present[ack_cpu];
    ack_std  = !crit_v[ack_cpu] && present[ack_cpu];
    ack_src  = crit_v[ack_cpu] ? crit_idx[ack_cpu] : best_idx[ack_cpu];
    ack_vec  = ack_take ? 8'(ack_src) : SPURIOUS;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NSRC; s++) cfg[s] <= '{crit: 1'b0, dest: '0, mask: 1'b1, prio: '0};
      for (int c = 0; c < NCPU; c++) begin
        task_pri[c]  <= '0;
        insvc_pri[c] <= '0;
      end
      for (int m = 0; m < NMSG; m++) msg_data[m] <= '0;
      insvc_v   <= '0;
      edge_pend <= '0;
      ser_mode  <= 1'b0;
      tmr_en    <= '0;
      tmr_casc  <= '0;
      irq_out   <= '0;
      crit_out  <= '0;
    end else begin
      irq_out  <= present;
      crit_out <= crit_v;
      if (wr_en) begin
        for (int s = 0; s < NSRC; s++)
          if (addr == ADDR_W'(s)) cfg[s] <= src_cfg_t'(wdata[7:0]);
        for (int c = 0; c < NCPU; c++) begin
          if (addr == ADDR_W'(A_TASK + c)) task_pri[c] <= wdata[PRI_W-1:0];
          if (addr == ADDR_W'(A_ACK + c))  insvc_v[c]  <= 1'b0;
        end
        if (addr == ADDR_W'(A_TCTL)) begin
          tmr_en   <= wdata[NTMR-1:0];
          tmr_casc <= wdata[2*NTMR-1:NTMR];
        end
        if (addr == ADDR_W'(A_MODE)) ser_mode <= wdata[0];
      end
      if (ack_hit && ack_take) begin
        for (int s = NEXT; s < NSRC; s++)
          if (ack_src == SRC_W'(s)) edge_pend[s] <= 1'b0;
        if (ack_std) begin
          insvc_v[ack_cpu]   <= 1'b1;
          insvc_pri[ack_cpu] <= best_pri[ack_cpu];
        end
      end
      // new events win over a same-cycle acknowledge
      for (int t = 0; t < NTMR; t++)
        if (tmr_wrap[t]) edge_pend[TMR_BASE + t] <= 1'b1;
      if (wr_en) begin
        for (int m = 0; m < NMSG; m++) begin
          if (addr == ADDR_W'(A_MSG + m)) begin
            msg_data[m]             <= wdata;
            edge_pend[MSG_BASE + m] <= 1'b1;
          end
        end
        if (addr == ADDR_W'(A_IPI)) begin
          for (int k = 0; k < NCPU; k++)
            if (wdata[k]) edge_pend[IPI_BASE + k] <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    rd_next = '0;
    for (int s = 0; s < NSRC; s++)
      if (addr == ADDR_W'(s)) rd_next = {{(DATA_W-8){1'b0}}, cfg[s]};
    for (int c = 0; c < NCPU; c++) begin
      if (addr == ADDR_W'(A_TASK + c)) rd_next = {{(DATA_W-PRI_W){1'b0}}, task_pri[c]};
      if (addr == ADDR_W'(A_ACK + c))  rd_next = {{(DATA_W-8){1'b0}}, ack_vec};
    end
    for (int m = 0; m < NMSG; m++)
      if (addr == ADDR_W'(A_MSG + m)) rd_next = msg_data[m];
    if (addr == ADDR_W'(A_TCTL)) rd_next = {{(DATA_W-2*NTMR){1'b0}}, tmr_casc, tmr_en};
    if (addr == ADDR_W'(A_MODE)) rd_next = {{(DATA_W-1){1'b0}}, ser_mode};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
  import irq_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic            rd_en,
  input logic [5:0]      addr,
  input logic [31:0]     wdata,
  input logic [31:0]     rd_data,
  input logic [NCPU-1:0] irq_out,
  input logic [NCPU-1:0] insvc_v,
  input logic            ser_done,
  input logic [NEXT-1:0] ser_bits
);
  // R13
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  // R8
  ser_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_done |=> $stable(ser_bits));

  for (genvar c = 0; c < NCPU; c++) begin : g_c
    // R3
    task_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 6'(A_TASK + c) && wdata[3:0] == 4'hF) |=> !irq_out[c]);

    // R5
    eoi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 6'(A_ACK + c) && !rd_en) |=> !insvc_v[c]);
  end
endmodule

bind mp_irq_ctrl irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rd_data(rd_data), .irq_out(irq_out), .insvc_v(insvc_v),
  .ser_done(ser_done), .ser_bits(ser_bits)
);

// File: tb/tb_mp_irq_ctrl.sv
module tb_mp_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  irq_in = '0;
  logic        ser_sync = 1'b0, ser_data = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_data;
  logic [3:0]  irq_out, crit_out;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  mp_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .ser_sync(ser_sync),
    .ser_data(ser_data), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rd_data(rd_data), .irq_out(irq_out), .crit_out(crit_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic frame(input logic [15:0] b);
    @(negedge clk); ser_sync = 1'b1;
    @(negedge clk); ser_sync = 1'b0; ser_data = b[15];
    for (int i = 14; i >= 0; i--) begin
      @(negedge clk); ser_data = b[i];
    end
    @(negedge clk); ser_data = 1'b0;
  endtask

  // spec arbitration: strictly greater, ascending scan keeps lowest index on ties
  function automatic logic [7:0] ref_pick(input logic [7:0] lv, input logic [3:0] p [8],
                                          input logic [7:0] m, input logic [3:0] tp);
    logic [7:0] w = 8'hFF;
    logic [3:0] wp = tp;
    for (int i = 0; i < 8; i++)
      if (lv[i] && !m[i] && p[i] != 0 && p[i] > wp) begin
        w = 8'(i); wp = p[i];
      end
    return w;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [3:0]  pr [8];
    logic [7:0]  mk, lv, e;
    logic [3:0]  tp;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq_out", 32'(irq_out), 32'h0);
    chk("R1 crit_out", 32'(crit_out), 32'h0);
    rd(6'd36, d); chk("R1 spurious ack", d, 32'hFF);
    rd(6'd5, d);  chk("R1 cfg masked", d, 32'h10);

    // R2 R7 R3 parallel line delivery
    wr(6'd3, 32'h25);
    rd(6'd3, d); chk("R2 cfg readback", d, 32'h25);
    irq_in = 8'h08; settle();
    chk("R7 line3 to cpu1", 32'(irq_out), 32'h2);

    // R4 R5 in-service and end of interrupt
    rd(6'd37, d); chk("R4 ack src3", d, 32'd3);
    settle(); chk("R4 in-service blocks equal", 32'(irq_out[1]), 32'h0);
    wr(6'd4, 32'h27); irq_in = 8'h18; settle();
    chk("R3 higher preempts", 32'(irq_out[1]), 32'h1);
    rd(6'd37, d); chk("R4 ack src4", d, 32'd4);
    settle(); chk("R4 in-service blocks", 32'(irq_out[1]), 32'h0);
    wr(6'd37, 0); settle();
    chk("R5 eoi reopens", 32'(irq_out[1]), 32'h1);
    irq_in = 8'h00; settle();
    rd(6'd37, d); chk("R4 spurious when idle", d, 32'hFF);
    wr(6'd4, 32'h10);

    // R3 task priority, R2 mask
    irq_in = 8'h08;
    wr(6'd33, 32'd5); settle(); chk("R3 task equal blocks", 32'(irq_out[1]), 32'h0);
    wr(6'd33, 32'd4); settle(); chk("R3 task lower passes", 32'(irq_out[1]), 32'h1);
    wr(6'd3, 32'h35); settle(); chk("R2 mask blocks", 32'(irq_out[1]), 32'h0);
    wr(6'd3, 32'h25); wr(6'd33, 32'd0);

    // R4 tie to lowest source
    wr(6'd6, 32'h25); irq_in = 8'h48; settle();
    rd(6'd37, d); chk("R4 tie lowest index", d, 32'd3);
    wr(6'd37, 0); irq_in = 8'h00; wr(6'd6, 32'h10);

    // R6 critical bypass
    wr(6'd2, 32'hC1); wr(6'd34, 32'd15); irq_in = 8'h04; settle();
    chk("R6 crit_out", 32'(crit_out), 32'h4);
    chk("R6 no standard", 32'(irq_out), 32'h0);
    rd(6'd38, d); chk("R6 ack critical", d, 32'd2);
    irq_in = 8'h00; settle();
    chk("R6 crit drops", 32'(crit_out), 32'h0);
    wr(6'd2, 32'h10); wr(6'd34, 32'd0);

    // R9 mailbox
    wr(6'd21, 32'h09); wr(6'd41, 32'hDEADBEEF); settle();
    chk("R9 mailbox irq", 32'(irq_out[0]), 32'h1);
    rd(6'd41, d); chk("R9 mailbox data", d, 32'hDEADBEEF);
    rd(6'd36, d); chk("R9 ack mailbox", d, 32'd21);
    wr(6'd36, 0); settle();
    chk("R9 edge cleared", 32'(irq_out[0]), 32'h0);

    // R10 doorbells
    for (int k = 24; k < 28; k++) wr(6'(k), 32'h03);
    wr(6'd44, 32'hA); settle();
    chk("R10 doorbell targets", 32'(irq_out), 32'hA);
    rd(6'd39, d); chk("R10 ack cpu3", d, 32'd27);
    rd(6'd37, d); chk("R10 ack cpu1", d, 32'd25);
    wr(6'd39, 0); wr(6'd37, 0); settle();
    chk("R10 cleared", 32'(irq_out), 32'h0);

    // R11 R12 timers: t0 reload 3, t1 reload 2 chained
    wr(6'd16, 32'h02); wr(6'd17, 32'h43);
    wr(6'd48, 32'd3); wr(6'd49, 32'd2);
    wr(6'd52, 32'h23);
    repeat (2) @(negedge clk); chk("R11 timer not yet", 32'(irq_out[0]), 32'h0);
    repeat (4) @(negedge clk); chk("R11 timer wrapped", 32'(irq_out[0]), 32'h1);
    repeat (2) @(negedge clk); chk("R12 chained not yet", 32'(irq_out[2]), 32'h0);
    repeat (12) @(negedge clk); chk("R12 chained wrapped", 32'(irq_out[2]), 32'h1);
    wr(6'd52, 32'h0);
    rd(6'd36, d); chk("R11 ack timer0", d, 32'd16);
    rd(6'd38, d); chk("R12 ack timer1", d, 32'd17);
    wr(6'd36, 0); wr(6'd38, 0); wr(6'd16, 32'h10); wr(6'd17, 32'h10);

    // R8 serial frames
    wr(6'd53, 32'd1); wr(6'd10, 32'h66); irq_in = 8'hFF; settle();
    chk("R8 parallel ignored", 32'(irq_out), 32'h0);
    frame(16'h0400); settle(); chk("R8 frame bit10", 32'(irq_out), 32'h8);
    frame(16'h0008); settle(); chk("R8 bit order", 32'(irq_out), 32'h2);
    frame(16'h0000); settle(); chk("R8 frame clear", 32'(irq_out), 32'h0);
    wr(6'd53, 32'd0); irq_in = 8'h00; wr(6'd10, 32'h10);

    // R13 read data hold
    rd(6'd3, d);
    wr(6'd11, 32'h10); repeat (5) @(negedge clk);
    chk("R13 rd_data held", rd_data, 32'h25);

    // R3 R4 seeded random arbitration on parallel lines, cpu0
    for (int s = 0; s < 28; s++) wr(6'(s), 32'h10);
    for (int it = 0; it < 40; it++) begin
      mk = 8'($urandom);
      lv = 8'($urandom);
      tp = 4'($urandom % 8);
      for (int i = 0; i < 8; i++) begin
        pr[i] = 4'($urandom);
        wr(6'(i), {24'h0, 1'b0, 2'b00, mk[i], pr[i]});
      end
      wr(6'd32, 32'(tp));
      irq_in = lv; settle();
      e = ref_pick(lv, pr, mk, tp);
      chk("R3 random irq_out", 32'(irq_out[0]), 32'(e != 8'hFF));
      rd(6'd36, d); chk("R4 random ack", d, 32'(e));
      wr(6'd36, 0);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule